// File: doc/BRIEF.md
# Reset Release Timer Sequencer

This block decides when the chip comes out of an external reset. While the reset pin is high the processor is held stopped and the configuration registers are told to load their defaults. The real-time clock keeps running the whole time. Once the pin drops, the block times a hold-off interval and then raises a wake signal. Wake lets the processor start fetching from its reset vector, address zero.

The length of the interval and the mode the chip starts in both depend on whether main system power is present when reset is released. With power present the block waits 4100 real-time-clock ticks and starts in full-power mode. With power absent it waits only two crystal ticks and reports a brownout start. Everything runs on one fast clock, and the two slower time bases reach the block as single-cycle tick enables.

Top module: `reset_release_seq`

## Requirements
- R1: `cpu_run` is low in any cycle where `ext_rst` is high, and it is high only while `wake` is high.
- R2: `cfg_default` is 1 from the first `clk` edge that samples `ext_rst` high up to the edge that samples the release, and it is 0 afterwards until reset is asserted again.
- R3: `wake` goes to 0 on the first `clk` edge that samples `ext_rst` high. The release is the first edge that samples `ext_rst` low again, and ticks are counted only on edges after it.
- R4: If `pwr_ok` is 1 on the release edge, `wake` rises on the edge that samples the 4100th `rtc_en` tick after the release, and `start_brownout` is 0. Pulses on `xtal_en` do not advance this count.
- R5: If `pwr_ok` is 0 on the release edge, `wake` rises on the edge that samples the 2nd `xtal_en` tick after the release, and `start_brownout` is 1. Pulses on `rtc_en` do not advance this count.
- R6: If `ext_rst` goes high again while the interval is being counted, the count is discarded. The next release starts a full new interval.
- R7: `pwr_ok` is sampled only on the release edge. Changes to it later in the interval or after wake alter neither the interval nor `start_brownout`.
- R8: Once high, `wake` stays high until `ext_rst` is sampled high. `wake` rises only on an edge where the tick enable of the selected interval is high.
- R9: After `rst_n` is released with `ext_rst` high, `wake` is 0, `cpu_run` is 0, `cfg_default` is 1 and `start_brownout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. All registers use it. |
| rst_n | input | 1 | Asynchronous active-low reset of the block. |
| ext_rst | input | 1 | External reset pin, already synchronised, high = reset. |
| pwr_ok | input | 1 | High when main system power is present. |
| rtc_en | input | 1 | One-cycle tick of the real-time clock. |
| xtal_en | input | 1 | One-cycle tick of the crystal clock. |
| wake | output | 1 | High once the hold-off interval has expired. |
| cpu_run | output | 1 | Run enable for the processor, which starts at address 0. |
| start_brownout | output | 1 | Start mode: 1 = brownout, 0 = full power. |
| cfg_default | output | 1 | Tells the configuration registers to hold their defaults. |

## Verification
The checker looks at every cycle for the following:
- the run enable is gated off during reset;
- wake falls and the defaults strobe rises one edge after reset is sampled;
- wake, once high, stays high;
- the start mode holds still while awake;
- wake rises only on a tick of the selected time base.

The exact length of each interval cannot be written as a simple property, because it spans thousands of cycles. The bench therefore shows it in its scenarios:
- the 4100-tick and 2-tick counts;
- the restart after reset is asserted again mid-count;
- the fact that `pwr_ok` is ignored after release.

A cycle-by-cycle reference model also compares all four outputs on every clock.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    RR_HOLD  = 2'd0,
    RR_COUNT = 2'd1,
    RR_AWAKE = 2'd2
  } rr_state_e;
endpackage

// File: rtl/rr_interval_counter.sv
module rr_interval_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_inc;
    end
  end

  assign done = !clear && tick && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rr_seq_fsm.sv
module rr_seq_fsm
  import rr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_rst,
  input  logic      pwr_ok,
  input  logic      done,
  output rr_state_e state,
  output logic      brownout,
  output logic      wake
);
  rr_state_e state_q, state_d;
  logic      bo_q, bo_d;
  logic      wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    bo_d    = bo_q;
    wake_d  = wake_q;
    if (ext_rst) begin
      state_d = RR_HOLD;
      wake_d  = 1'b0;
    end else begin
      case (state_q)
        RR_HOLD: begin
          state_d = RR_COUNT;
          bo_d    = !pwr_ok;
        end
        RR_COUNT: begin
          if (done) begin
            state_d = RR_AWAKE;
            wake_d  = 1'b1;
          end
        end
        RR_AWAKE: state_d = RR_AWAKE;
        default:  state_d = RR_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RR_HOLD;
      bo_q    <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bo_q    <= bo_d;
      wake_q  <= wake_d;
    end
  end

  assign state    = state_q;
  assign brownout = bo_q;
  assign wake     = wake_q;
endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
  import rr_pkg::*;
#(
  parameter int RTC_DELAY  = 4100,
  parameter int XTAL_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic pwr_ok,
  input  logic rtc_en,
  input  logic xtal_en,
  output logic wake,
  output logic cpu_run,
  output logic start_brownout,
  output logic cfg_default
);
  localparam int MAX_DELAY = (RTC_DELAY > XTAL_DELAY) ? RTC_DELAY : XTAL_DELAY;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  rr_state_e        state;
  logic             brownout;
  logic             done;
  logic             tick_sel;
  logic [CNT_W-1:0] limit_sel;

  assign tick_sel  = brownout ? xtal_en : rtc_en;
  assign limit_sel = brownout ? CNT_W'(XTAL_DELAY) : CNT_W'(RTC_DELAY);

  rr_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_rst  (ext_rst),
    .pwr_ok   (pwr_ok),
    .done     (done),
    .state    (state),
    .brownout (brownout),
    .wake     (wake)
  );

  rr_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != RR_COUNT),
    .tick  (tick_sel),
    .limit (limit_sel),
    .done  (done)
  );

  assign cpu_run        = wake && !ext_rst;
  assign start_brownout = brownout;
  assign cfg_default    = (state == RR_HOLD);
endmodule

// File: rtl/rr_release_checker.sv
module rr_release_checker (
  input logic clk,
  input logic rst_n,
  input logic ext_rst,
  input logic pwr_ok,
  input logic rtc_en,
  input logic xtal_en,
  input logic wake,
  input logic cpu_run,
  input logic start_brownout,
  input logic cfg_default
);
  assert_run_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (wake && !ext_rst));

  assert_defaults_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> cfg_default);

  assert_wake_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> !wake);

  assert_rise_on_rtc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake) && !start_brownout) |-> $past(rtc_en));

  assert_rise_on_xtal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake) && start_brownout) |-> $past(xtal_en));

  assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && $past(wake)) |-> $stable(start_brownout));

  assert_wake_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !ext_rst) |=> wake);

  assert_no_defaults_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !cfg_default);
endmodule

bind reset_release_seq rr_release_checker u_chk (.*);

// File: tb/tb_reset_release_seq.sv
`timescale 1ns/1ps
module tb_reset_release_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b1;
  logic pwr_ok = 1'b1;
  logic rtc_en = 1'b0;
  logic xtal_en = 1'b0;
  logic wake, cpu_run, start_brownout, cfg_default;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rtc_div = 0;
  int xtal_div = 0;

  always #10 clk = ~clk;

  reset_release_seq dut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .pwr_ok(pwr_ok),
    .rtc_en(rtc_en), .xtal_en(xtal_en), .wake(wake), .cpu_run(cpu_run),
    .start_brownout(start_brownout), .cfg_default(cfg_default)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // tick generators: rtc every 3 clocks, crystal every 2 clocks (offset)
  always @(negedge clk) begin
    rtc_div  = (rtc_div + 1) % 3;
    xtal_div = (xtal_div + 1) % 2;
    rtc_en  <= (rtc_div == 0);
    xtal_en <= (xtal_div == 1);
  end

  // behavioural reference model
  int  m_phase = 0;   // 0 held, 1 timing, 2 awake
  int  m_ticks = 0;
  bit  m_bo = 0;
  bit  m_wake = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_bo = 0; m_wake = 0;
    end else if (ext_rst) begin
      m_phase = 0; m_ticks = 0; m_wake = 0;
    end else if (m_phase == 0) begin
      m_phase = 1; m_ticks = 0; m_bo = !pwr_ok;
    end else if (m_phase == 1) begin
      if (m_bo ? xtal_en : rtc_en) m_ticks++;
      if (m_ticks == (m_bo ? 2 : 4100)) begin
        m_phase = 2; m_wake = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "model wake", wake, m_wake);
      chk("R1", "model cpu_run", cpu_run, m_wake && !ext_rst);
      chk("R2", "model cfg_default", cfg_default, m_phase == 0);
      chk("R7", "model start_brownout", start_brownout, m_bo);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
      finish_run();
    end
  end

  // release reset and time the interval in ticks of the selected base
  task automatic timed_release(input bit pwr, input bit bo_exp, input int exp_ticks,
                               input bit toggle_pwr, input string req);
    int n = 0;
    bit last_tk = 0;
    @(negedge clk);
    pwr_ok  = pwr;
    ext_rst = 1'b0;
    @(posedge clk);              // release edge: ticks here are not counted
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      last_tk = bo_exp ? xtal_en : rtc_en;
      if (last_tk) n++;
      @(negedge clk);
      if (toggle_pwr) pwr_ok = ~pwr_ok;
      if (wake) break;
    end
    chk(req, "ticks to wake", n, exp_ticks);
    chk(req, "wake rose on selected tick", last_tk, 1);
    chk(req, "start_brownout", start_brownout, bo_exp);
    chk("R1", "cpu_run after wake", cpu_run, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R9: state after block reset with the pin held
    chk("R9", "wake after rst_n", wake, 0);
    chk("R9", "cpu_run after rst_n", cpu_run, 0);
    chk("R9", "cfg_default after rst_n", cfg_default, 1);
    chk("R9", "start_brownout after rst_n", start_brownout, 0);

    // R4: power present
    timed_release(1'b1, 1'b0, 4100, 1'b0, "R4");

    // R8: wake holds while awake, even with pwr_ok moving (R7)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pwr_ok = ~pwr_ok;
    end
    chk("R8", "wake holds", wake, 1);
    chk("R7", "mode ignores pwr_ok after wake", start_brownout, 0);

    // R1/R3: assert the pin
    @(negedge clk);
    ext_rst = 1'b1;
    #1;
    chk("R1", "cpu_run gated by pin", cpu_run, 0);
    @(negedge clk);
    chk("R3", "wake drops", wake, 0);
    chk("R2", "defaults asserted", cfg_default, 1);
    repeat (3) @(negedge clk);

    // R5: power absent
    timed_release(1'b0, 1'b1, 2, 1'b0, "R5");
    chk("R2", "defaults off when awake", cfg_default, 0);
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (2) @(negedge clk);

    // R6: reassert mid count, then full new interval
    pwr_ok  = 1'b1;
    ext_rst = 1'b0;
    repeat (1500) @(negedge clk);
    chk("R6", "no wake mid count", wake, 0);
    chk("R2", "defaults off while timing", cfg_default, 0);
    ext_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6", "defaults back on", cfg_default, 1);
    timed_release(1'b1, 1'b0, 4100, 1'b0, "R6");
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (2) @(negedge clk);

    // R7: pwr_ok toggles during the count, sampled only at release
    timed_release(1'b0, 1'b1, 2, 1'b1, "R7");
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (2) @(negedge clk);
    timed_release(1'b1, 1'b0, 4100, 1'b1, "R7");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule